// File: doc/BRIEF.md
# Configurable-Format Serial Frame Transmitter

This block turns bytes into asynchronous serial frames on a single output line. A byte is handed over on a valid/ready handshake. The block then sends a low start bit, the data bits least-significant first, an optional parity bit and one or more high stop bits. When nothing is being sent, the line rests high.

An 8-bit line control word sets the frame format. It selects a data length of 5 to 8 bits, no parity, odd, even or forced parity, and a stop period of 1, 1.5 or 2 bit times. It also carries a break control that pulls the line low. Bit timing comes from a baud tick input that pulses at sixteen times the bit rate. The block samples the format when a frame starts, so software can rewrite the control word at any time without corrupting the frame in flight.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, `txOut` is 1, `busy` is 0 and `inReady` is 1 while the control word is 0.
- R2: `lineCtl[1:0]` selects the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. A frame is one low start bit followed by `inData` bits 0 upward up to that length. Higher data bits are never sent.
- R3: With `lineCtl[3]` at 1, one parity bit follows the data bits. With `lineCtl[3]` at 0, no parity bit is sent and `lineCtl[5:4]` have no effect.
- R4: With parity on and `lineCtl[5]` at 0, `lineCtl[4]` at 0 makes the count of ones in the sent data plus parity odd, and at 1 makes it even.
- R5: With parity on and `lineCtl[5]` at 1, the parity bit is 1 when `lineCtl[4]` is 0 and 0 when `lineCtl[4]` is 1, whatever the data.
- R6: The stop period is high. It lasts 16 ticks when `lineCtl[2]` is 0, 24 ticks when `lineCtl[2]` is 1 with 5-bit data, and 32 ticks when `lineCtl[2]` is 1 with 6 to 8 data bits. `busy` falls on the edge that takes the last stop tick.
- R7: Each start, data and parity bit lasts exactly 16 baud ticks, counted from the accepting clock edge. Without a tick, the frame does not advance.
- R8: While `lineCtl[6]` is 1, `txOut` is 0 in the same cycle, even in mid-frame. The frame timing keeps running underneath, and normal output returns as soon as the bit clears.
- R9: While `lineCtl[6]` is 1, no byte is accepted. A byte offered during break is taken once break is cleared.
- R10: The format fields are captured at the accepting edge. A control word change during a frame affects only later frames.
- R11: `lineCtl[7]` has no effect on the frame.
- R12: `inReady` is 1 only when the block is idle and break is clear. An accepted byte raises `busy` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| baudTick | input | 1 | One-cycle pulse at 16x the bit rate |
| lineCtl | input | 8 | Line control word (format, parity, stop, break) |
| inData | input | 8 | Byte to send |
| inValid | input | 1 | Byte offered |
| inReady | output | 1 | Byte can be accepted this cycle |
| txOut | output | 1 | Serial line, idles high |
| busy | output | 1 | Frame in progress |

## Verification
Two events can land in the same cycle: the break control rising and a byte being offered on the handshake. The bench raises break and `inValid` on the same edge. It then checks that `inReady` stays low and that `busy` never rises while break holds. On release, the pending byte must go out with a correct start and data bits. The second overlap is a control word rewrite during a running frame, which is also done while break toggles mid-frame. The bench judges both by sampling the line at the middle of each bit and by checking the exact tick on which `busy` falls.

// File: rtl/sftx_pkg.sv
package sftx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } txState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic     load;
    logic     shift;
    txState_e sel;
  } txStrobe_t;

  // mask keeping only the active data bits for a length code
  function automatic logic [7:0] lenMask(input logic [1:0] code);
    return 8'hFF >> (2'd3 - code);
  endfunction

  // parity bit from masked data: stick mode wins over odd/even
  function automatic logic calcParity(input logic [7:0] bits,
                                      input logic evenSel,
                                      input logic stickSel);
    if (stickSel) return ~evenSel;
    return evenSel ? ^bits : ~^bits;
  endfunction

endpackage

// File: rtl/sftx_ctrl.sv
module sftx_ctrl
  import sftx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      baudTick,
  input  logic [3:0] fmtCtl,
  input  logic      breakOn,
  input  logic      inValid,
  output logic      inReady,
  output logic      busy,
  output txStrobe_t strobe
);

  localparam int TW = $clog2(2 * OVERSAMPLE);
  localparam logic [TW-1:0] BIT_LAST   = TW'(OVERSAMPLE - 1);
  localparam logic [TW-1:0] HALF3_LAST = TW'(OVERSAMPLE + OVERSAMPLE / 2 - 1);
  localparam logic [TW-1:0] TWO_LAST   = TW'(2 * OVERSAMPLE - 1);

  txState_e      state;
  logic [TW-1:0] tickCnt;
  logic [TW-1:0] stopLast;
  logic [TW-1:0] curLast;
  logic [2:0]    bitCnt;
  logic [2:0]    lenM1;
  logic          parOn;
  logic          accept;
  logic          bitDone;

  assign inReady = (state == ST_IDLE) && !breakOn;
  assign accept  = inValid && inReady;
  assign busy    = (state != ST_IDLE);
  assign curLast = (state == ST_STOP) ? stopLast : BIT_LAST;
  assign bitDone = baudTick && (tickCnt == curLast);

  assign strobe.load  = accept;
  assign strobe.shift = bitDone && (state == ST_DATA);
  assign strobe.sel   = state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tickCnt  <= '0;
      bitCnt   <= '0;
      lenM1    <= 3'd7;
      parOn    <= 1'b0;
      stopLast <= BIT_LAST;
    end else if (state == ST_IDLE) begin
      if (accept) begin
        state   <= ST_START;
        tickCnt <= '0;
        bitCnt  <= '0;
        lenM1   <= 3'd4 + {1'b0, fmtCtl[1:0]};
        parOn   <= fmtCtl[3];
        if (!fmtCtl[2])
          stopLast <= BIT_LAST;
        else if (fmtCtl[1:0] == 2'b00)
          stopLast <= HALF3_LAST;
        else
          stopLast <= TWO_LAST;
      end
    end else if (baudTick) begin
      if (bitDone) begin
        tickCnt <= '0;
        unique case (state)
          ST_START: begin
            state  <= ST_DATA;
            bitCnt <= '0;
          end
          ST_DATA: begin
            if (bitCnt == lenM1)
              state <= parOn ? ST_PARITY : ST_STOP;
            else
              bitCnt <= bitCnt + 3'd1;
          end
          ST_PARITY: state <= ST_STOP;
          ST_STOP:   state <= ST_IDLE;
          default:   state <= ST_IDLE;
        endcase
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  // R12: an accepted byte starts a frame
  a_r12_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> busy);

  // R9: break keeps an idle block idle
  a_r9_break_hold: assert property (@(posedge clk) disable iff (!rstN)
    (breakOn && !busy) |=> !busy);

  // R7: nothing moves without a tick or a handshake
  a_r7_no_tick_no_move: assert property (@(posedge clk) disable iff (!rstN)
    (!baudTick && !accept) |=> $stable(state));

  // R2: data bit index never passes the sampled length
  a_r2_bitcnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA) |-> (bitCnt <= lenM1));

endmodule

// File: rtl/sftx_datapath.sv
module sftx_datapath
  import sftx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] lenCode,
  input  logic [1:0] parMode,
  input  logic       breakOn,
  input  logic [7:0] inData,
  input  txStrobe_t  strobe,
  output logic       txOut
);

  logic [7:0] shiftReg;
  logic       parBit;
  logic       lineBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else if (strobe.load) begin
      shiftReg <= inData;
      parBit   <= calcParity(inData & lenMask(lenCode), parMode[0], parMode[1]);
    end else if (strobe.shift) begin
      shiftReg <= {1'b0, shiftReg[7:1]};
    end
  end

  always_comb begin
    unique case (strobe.sel)
      ST_START:  lineBit = 1'b0;
      ST_DATA:   lineBit = shiftReg[0];
      ST_PARITY: lineBit = parBit;
      default:   lineBit = 1'b1;
    endcase
  end

  assign txOut = breakOn ? 1'b0 : lineBit;

  // R2: a load is followed by a low start bit
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (strobe.sel == ST_START && lineBit == 1'b0));

  // R6: stop period drives the line high
  a_r6_stop_high: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sel == ST_STOP) |-> lineBit);

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sftx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic [7:0] lineCtl,
  input  logic [7:0] inData,
  input  logic       inValid,
  output logic       inReady,
  output logic       txOut,
  output logic       busy
);

  txStrobe_t strobe;
  logic      unusedDivLatch;

  assign unusedDivLatch = lineCtl[7];

  sftx_ctrl #(.OVERSAMPLE(OVERSAMPLE)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .baudTick (baudTick),
    .fmtCtl   (lineCtl[3:0]),
    .breakOn  (lineCtl[6]),
    .inValid  (inValid),
    .inReady  (inReady),
    .busy     (busy),
    .strobe   (strobe)
  );

  sftx_datapath i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .lenCode (lineCtl[1:0]),
    .parMode (lineCtl[5:4]),
    .breakOn (lineCtl[6]),
    .inData  (inData),
    .strobe  (strobe),
    .txOut   (txOut)
  );

  // R8: break holds the line low
  a_r8_break_low: assert property (@(posedge clk) disable iff (!rstN)
    lineCtl[6] |-> !txOut);

endmodule

// File: tb/test_serial_frame_tx.sv
module test_serial_frame_tx;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN, baudTick, inValid, inReady, txOut, busy;
  logic [7:0] lineCtl, inData;
  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 0;

  serial_frame_tx i_serial_frame_tx (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .lineCtl(lineCtl),
    .inData(inData), .inValid(inValid), .inReady(inReady),
    .txOut(txOut), .busy(busy)
  );

  // parity: -1 none; stop: ticks
  localparam int NV = 10;
  localparam logic [7:0] V_CTL [NV] = '{8'h03, 8'h1B, 8'h0B, 8'h2A, 8'h3A,
                                        8'h04, 8'h05, 8'h0C, 8'h9E, 8'h12};
  localparam logic [7:0] V_DAT [NV] = '{8'hA5, 8'h07, 8'h07, 8'h00, 8'hFF,
                                        8'hFF, 8'h2C, 8'hE3, 8'h81, 8'h55};
  // R3 none / R4 even / R4 odd / R5 stuck 1 / R5 stuck 0 / none / none /
  // R4 odd 5-bit / R4 even plus R11 bit 7 set / R3 mode bits ignored
  localparam int V_PAR  [NV] = '{-1, 1, 0, 1, 0, -1, -1, 1, 1, -1};
  localparam int V_STOP [NV] = '{16, 16, 16, 16, 16, 24, 32, 24, 32, 16};

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick1();
    baudTick = 1'b1;
    @(negedge clk);
    baudTick = 1'b0;
    @(negedge clk);
  endtask

  task automatic tickN(input int n);
    for (int i = 0; i < n; i++) tick1();
  endtask

  task automatic startFrame(input logic [7:0] ctl, input logic [7:0] dat);
    lineCtl = ctl;
    inData  = dat;
    inValid = 1'b1;
    #1;
    check("R12 ready when idle", int'(inReady), 1);
    @(negedge clk);
    inValid = 1'b0;
    check("R12 busy after accept", int'(busy), 1);
  endtask

  task automatic runFrame(input int idx);
    int len, nBits, total, b, expBit;
    len   = 5 + int'(V_CTL[idx][1:0]);
    nBits = 1 + len + ((V_PAR[idx] >= 0) ? 1 : 0);
    total = 16 * nBits + V_STOP[idx];
    startFrame(V_CTL[idx], V_DAT[idx]);
    for (int t = 0; t < total; t++) begin
      if (t % 16 == 8) begin
        b = t / 16;
        if (b == 0) expBit = 0;
        else if (b <= len) expBit = int'(V_DAT[idx][b-1]);
        else if (b == len + 1 && V_PAR[idx] >= 0) expBit = V_PAR[idx];
        else expBit = 1;
        if (b == len + 1 && V_PAR[idx] >= 0)
          check($sformatf("R3/R4/R5/R11 parity vec%0d", idx), int'(txOut), expBit);
        else
          check($sformatf("R2/R7 bit%0d vec%0d", b, idx), int'(txOut), expBit);
      end
      if (t == total - 1)
        check($sformatf("R6 busy before last stop tick vec%0d", idx), int'(busy), 1);
      tick1();
    end
    check($sformatf("R6 idle after stop vec%0d", idx), int'(busy), 0);
    check($sformatf("R6 line high after frame vec%0d", idx), int'(txOut), 1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual 0 expected 1 (run finished)");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; baudTick = 1'b0; inValid = 1'b0;
    lineCtl = 8'h00; inData = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset txOut", int'(txOut), 1);
    check("R1 reset busy", int'(busy), 0);
    check("R1 reset inReady", int'(inReady), 1);

    // R7: ticks while idle change nothing
    tickN(5);
    check("R7 idle ticks busy", int'(busy), 0);

    for (int i = 0; i < NV; i++) runFrame(i);

    // R9 / R8: break raised on the same edge a byte is offered
    lineCtl = 8'h43; inData = 8'h5A; inValid = 1'b1;
    #1;
    check("R9 no ready in break", int'(inReady), 0);
    check("R8 line low in break", int'(txOut), 0);
    tickN(20);
    check("R9 pending byte held", int'(busy), 0);
    lineCtl = 8'h03;
    #1;
    check("R9 ready after release", int'(inReady), 1);
    @(negedge clk);
    inValid = 1'b0;
    check("R9 byte taken after release", int'(busy), 1);
    tickN(8);
    check("R9 start bit", int'(txOut), 0);
    tickN(16);
    check("R9 data bit0", int'(txOut), 0);
    tickN(16);
    check("R9 data bit1", int'(txOut), 1);
    tickN(120);
    check("R9 frame end", int'(busy), 0);

    // R8: break in mid-frame
    startFrame(8'h03, 8'hFF);
    tickN(20);
    check("R8 before break", int'(txOut), 1);
    lineCtl = 8'h43;
    #1;
    check("R8 break mid-frame low", int'(txOut), 0);
    tickN(10);
    check("R8 still low", int'(txOut), 0);
    check("R8 frame continues", int'(busy), 1);
    lineCtl = 8'h03;
    #1;
    check("R8 release restores data", int'(txOut), 1);
    tickN(130);
    check("R8 frame timing unchanged", int'(busy), 0);

    // R10: control rewrite mid-frame only affects later frames
    startFrame(8'h03, 8'h00);
    tickN(24);
    lineCtl = 8'h1F;
    tickN(128);
    check("R10 no parity inserted", int'(txOut), 1);
    tickN(7);
    check("R10 old stop length busy", int'(busy), 1);
    tickN(1);
    check("R10 old stop length idle", int'(busy), 0);

    done = 1;
    summary();
    $finish;
  end

endmodule